// File: doc/BRIEF.md
# Auto-Null Step Controller

This block steers a stepped digital potentiometer that trims the input offset of a precision amplifier. During an adjust phase the amplifier's input source is disconnected and the amplifier runs open-loop, so its output rails to one side according to the sign of the remaining offset. That sign comes back to the block as a single bit. When the adjust phase ends, the block moves the wiper one position in the direction that reduces the offset. Repeated adjust cycles walk the wiper toward null. The wiper then stays where it is until the next null operation.

Adjust phases come from one of three sources. The first is an external strobe. The second is an internal clock of about 1 kHz, divided down from the system clock, which runs only while an auto-null enable is held high. The third is a run of a fixed number of internal adjust cycles that starts by itself when the power-good indication rises. The block keeps a 7-bit mirror of the wiper position. The mirror stops at both ends of the travel, and the block never sends a step beyond either end.

Top module: `nullstep_ctrl`

## Requirements
- R1: While reset is low, and on the first clock after it, the outputs are as follows: `dir_up` = 0, `step_pulse` = 0, `adj_mode` = 0 and `wiper_pos` = INIT_POS (default 50).
- R2: `adj_ext` reaches `adj_mode` through a two-flop synchroniser. `adj_mode` follows a change on `adj_ext` after exactly two rising clock edges, provided the internal adjust clock is idle.
- R3: Each high-to-low transition of `adj_mode` produces at most one step. The step is a `step_pulse` that is high for exactly one clock, and it appears on the second rising edge after `adj_mode` falls. At other times `step_pulse` stays low.
- R4: The direction is set by the synchronised `sign_in`, sampled as the adjust phase ends. A value of 1 sets `dir_up` = 1 and raises `wiper_pos` by one. A value of 0 sets `dir_up` = 0 and lowers `wiper_pos` by one. `dir_up` takes its new value at least one clock before `step_pulse` rises and does not change while `step_pulse` is high.
- R5: The block issues no step that would move `wiper_pos` above POSITIONS-1 (99) or below 0. At an end of travel, an adjust cycle that points outward leaves `wiper_pos` unchanged and produces no `step_pulse`.
- R6: While `auto_en` is high, `adj_mode` toggles on its own, staying high for exactly DIV_HALF clocks in each period. While `auto_en` is low and no power-up run is active, the internal clock is held low.
- R7: A rising edge on `pwr_ok` starts an internal run of exactly AUTO_CYCLES adjust cycles, whatever the level of `auto_en`. After that run the internal clock stops.
- R8: When no adjust cycle ends, `wiper_pos` holds its value and `step_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sign_in | input | 1 | Sign of the open-loop amplifier output. 1 requests an up step. Asynchronous. |
| adj_ext | input | 1 | External adjust strobe. High means adjust phase. Asynchronous. |
| auto_en | input | 1 | Enables the internal adjust clock. Asynchronous. |
| pwr_ok | input | 1 | Power-good indication. Its rising edge starts an automatic null. Asynchronous. |
| dir_up | output | 1 | Step direction to the potentiometer. 1 means up. |
| step_pulse | output | 1 | One-clock step strobe to the potentiometer |
| adj_mode | output | 1 | Adjust phase. Disconnects the input source and opens the loop. |
| wiper_pos | output | POS_W (7) | Mirror of the wiper position, 0 to POSITIONS-1 |

## Verification
The stepping function is driven in three ways. External strobes with a fixed sign check the up and down direction along with the strobe-to-step latency. A power-up run with `auto_en` low checks that the number of adjust cycles matches AUTO_CYCLES exactly. Long free-running auto-null periods with a constant sign drive the wiper into each end of travel, which separates correct saturation from wrap-around or overstepping. A quiet stretch between operations, followed by outward external strobes at the lower end, shows that the position changes only when an adjust cycle ends, and only in an allowed direction.

// File: rtl/nullstep_pkg.sv
// Package: shared types for the auto-null step controller.
// Assumes nothing beyond the standard language.
package nullstep_pkg;
    // Encoding of the potentiometer step direction
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/nullstep_sync.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous level inputs.
// Assumes: each bit is an independent slow level, so per-bit capture is acceptable.
module nullstep_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the sampled levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nullstep_tick.sv
// Module: gated internal adjust clock. It divides clk by 2*DIV_HALF while enabled.
// A rising edge on pwr_ok enables it for exactly AUTO_CYCLES periods.
// Assumes: DIV_HALF >= 2, AUTO_CYCLES >= 1, and inputs already synchronised.
module nullstep_tick #(
    parameter int DIV_HALF    = 62500,
    parameter int AUTO_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic pwr_ok,
    output logic phase
);
    localparam int CNT_W = $clog2(DIV_HALF + 1);
    localparam int AC_W  = $clog2(AUTO_CYCLES + 1);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_HALF - 1);
    localparam logic [AC_W-1:0]  RUN_LAST = AC_W'(AUTO_CYCLES - 1);

    logic [CNT_W-1:0] div_cnt;
    logic [AC_W-1:0]  pu_cnt;
    logic             pwr_q;
    logic             pu_active;
    logic             run;
    logic             toggle;

    assign run    = auto_en | pu_active;
    assign toggle = run && (div_cnt == DIV_LAST);

    // Remember the previous power-good level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_ok;
    end

    // Half-period counter; held at zero while the clock is gated off
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_cnt <= '0;
        else if (toggle)    div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    // Internal adjust phase; forced low while gated off
    always_ff @(posedge clk) begin
        if (!rst_n || !run) phase <= 1'b0;
        else if (toggle)    phase <= ~phase;
    end

    // Power-up run: count falling phase edges and stop after AUTO_CYCLES
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_active <= 1'b0;
            pu_cnt    <= '0;
        end else if (pwr_ok && !pwr_q) begin
            pu_active <= 1'b1;
            pu_cnt    <= '0;
        end else if (pu_active && toggle && phase) begin
            if (pu_cnt == RUN_LAST) pu_active <= 1'b0;
            else                    pu_cnt    <= pu_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nullstep_wiper.sv
// Module: turns the end of each adjust phase into one saturating wiper step.
// The direction is registered one clock before the step strobe.
// Assumes: adj_mode never rises and falls again within two clocks.
module nullstep_wiper
    import nullstep_pkg::*;
#(
    parameter int POS_W    = 7,
    parameter int POS_MAX  = 99,
    parameter int INIT_POS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adj_mode,
    input  logic             sign,
    output logic             dir_up,
    output logic             step_pulse,
    output logic [POS_W-1:0] wiper_pos
);
    localparam logic [POS_W-1:0] TOP  = POS_W'(POS_MAX);
    localparam logic [POS_W-1:0] INIT = POS_W'(INIT_POS);

    step_dir_e dir_q;
    logic      adj_q;
    logic      fall;
    logic      pend;
    logic      allow;

    assign fall  = adj_q & ~adj_mode;
    assign allow = pend && ((dir_q == STEP_UP) ? (wiper_pos != TOP)
                                               : (wiper_pos != '0));

    // Delay the adjust level by one clock to find its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) adj_q <= 1'b0;
        else        adj_q <= adj_mode;
    end

    // Latch the sign at the end of the adjust phase and arm one step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= STEP_DOWN;
            pend  <= 1'b0;
        end else begin
            pend <= fall;
            if (fall) dir_q <= sign ? STEP_UP : STEP_DOWN;
        end
    end

    // Issue the step strobe and move the position mirror within range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_pulse <= 1'b0;
            wiper_pos  <= INIT;
        end else begin
            step_pulse <= allow;
            if (allow) begin
                if (dir_q == STEP_UP) wiper_pos <= wiper_pos + 1'b1;
                else                  wiper_pos <= wiper_pos - 1'b1;
            end
        end
    end

    assign dir_up = (dir_q == STEP_UP);
endmodule

// File: rtl/nullstep_ctrl.sv
// Module: top of the auto-null step controller. It synchronises the asynchronous
// controls, merges the external and internal adjust phases, and drives the
// potentiometer step interface.
// Assumes: the external strobe levels last at least two clocks each.
module nullstep_ctrl #(
    parameter int DIV_HALF    = 62500,
    parameter int AUTO_CYCLES = 100,
    parameter int POSITIONS   = 100,
    parameter int INIT_POS    = 50,
    parameter int POS_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sign_in,
    input  logic             adj_ext,
    input  logic             auto_en,
    input  logic             pwr_ok,
    output logic             dir_up,
    output logic             step_pulse,
    output logic             adj_mode,
    output logic [POS_W-1:0] wiper_pos
);
    localparam int POS_MAX = POSITIONS - 1;
    localparam int N_IN    = 4;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] syn_in;
    logic            int_phase;

    assign raw_in = {pwr_ok, auto_en, adj_ext, sign_in};

    nullstep_sync #(.W(N_IN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    nullstep_tick #(.DIV_HALF(DIV_HALF), .AUTO_CYCLES(AUTO_CYCLES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (syn_in[2]),
        .pwr_ok  (syn_in[3]),
        .phase   (int_phase)
    );

    // Adjust phase is active from either source
    assign adj_mode = syn_in[1] | int_phase;

    nullstep_wiper #(.POS_W(POS_W), .POS_MAX(POS_MAX), .INIT_POS(INIT_POS)) u_wiper (
        .clk        (clk),
        .rst_n      (rst_n),
        .adj_mode   (adj_mode),
        .sign       (syn_in[0]),
        .dir_up     (dir_up),
        .step_pulse (step_pulse),
        .wiper_pos  (wiper_pos)
    );
endmodule

// File: rtl/nullstep_chk.sv
// Checker: temporal properties of the step interface, bound to nullstep_ctrl.
module nullstep_chk #(
    parameter int POS_W   = 7,
    parameter int POS_MAX = 99
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adj_mode,
    input logic             dir_up,
    input logic             step_pulse,
    input logic [POS_W-1:0] wiper_pos
);
    // R3
    step_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    // R3
    step_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_pulse) |-> ($past(adj_mode, 3) && !$past(adj_mode, 2)));

    // R4
    dir_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $stable(dir_up));

    // R4
    up_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_pulse) && dir_up |-> wiper_pos == $past(wiper_pos) + 1'b1);

    // R4
    down_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_pulse) && !dir_up |-> wiper_pos == $past(wiper_pos) - 1'b1);

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_pos <= POS_W'(POS_MAX));

    // R8
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(step_pulse) |-> $stable(wiper_pos));
endmodule

bind nullstep_ctrl nullstep_chk #(.POS_W(POS_W), .POS_MAX(POS_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adj_mode   (adj_mode),
    .dir_up     (dir_up),
    .step_pulse (step_pulse),
    .wiper_pos  (wiper_pos)
);

// File: tb/nullstep_ctrl_test.sv
`timescale 1ns/1ps
module nullstep_ctrl_test;
    localparam int DIV_HALF    = 8;
    localparam int AUTO_CYCLES = 5;
    localparam int POSITIONS   = 100;
    localparam int INIT_POS    = 50;
    localparam int POS_W       = 7;
    localparam int POS_MAX     = POSITIONS - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sign_in = 1'b0, adj_ext = 1'b0, auto_en = 1'b0, pwr_ok = 1'b0;
    logic dir_up, step_pulse, adj_mode;
    logic [POS_W-1:0] wiper_pos;

    typedef struct { bit up; int pos; } exp_t;
    exp_t exp_q[$];

    int n_tests = 0, n_fail = 0;
    int model_pos = INIT_POS;
    bit sgn = 1'b0;
    int fall_cnt = 0, pulse_cnt = 0, hi_len = 0;
    bit width_chk = 1'b0, prev_adj = 1'b0, prev_step = 1'b0, prev_dir = 1'b0;
    bit done = 1'b0;

    nullstep_ctrl #(.DIV_HALF(DIV_HALF), .AUTO_CYCLES(AUTO_CYCLES),
        .POSITIONS(POSITIONS), .INIT_POS(INIT_POS), .POS_W(POS_W)) uut (
        .clk(clk), .rst_n(rst_n), .sign_in(sign_in), .adj_ext(adj_ext),
        .auto_en(auto_en), .pwr_ok(pwr_ok), .dir_up(dir_up),
        .step_pulse(step_pulse), .adj_mode(adj_mode), .wiper_pos(wiper_pos));

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor and predictor, both sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (step_pulse) begin
                pulse_cnt++;
                check(!prev_step, "R3 one-clock pulse", 1, 0);
                check(dir_up == prev_dir, "R4 dir setup", int'(dir_up), int'(prev_dir));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected step", int'(wiper_pos), model_pos);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(dir_up == e.up, "R4 direction", int'(dir_up), int'(e.up));
                    check(int'(wiper_pos) == e.pos, "R4 position", int'(wiper_pos), e.pos);
                end
            end
            if (adj_mode) hi_len++;
            if (prev_adj && !adj_mode) begin
                fall_cnt++;
                if (width_chk) check(hi_len == DIV_HALF, "R6 high width", hi_len, DIV_HALF);
                if (sgn && model_pos < POS_MAX) begin
                    model_pos++;
                    exp_q.push_back('{1'b1, model_pos});
                end else if (!sgn && model_pos > 0) begin
                    model_pos--;
                    exp_q.push_back('{1'b0, model_pos});
                end
            end
            if (!adj_mode) hi_len = 0;
            prev_adj  = adj_mode;
            prev_step = step_pulse;
            prev_dir  = dir_up;
        end
    end

    task automatic set_sign(input bit s);
        @(negedge clk);
        sgn = s;
        sign_in = s;
        repeat (4) @(negedge clk);
    endtask

    task automatic ext_cycle(input bit s);
        set_sign(s);
        adj_ext = 1'b1;
        repeat (6) @(negedge clk);
        adj_ext = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int f0, p0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(dir_up == 1'b0, "R1 dir_up", int'(dir_up), 0);
        check(step_pulse == 1'b0, "R1 step_pulse", int'(step_pulse), 0);
        check(adj_mode == 1'b0, "R1 adj_mode", int'(adj_mode), 0);
        check(int'(wiper_pos) == INIT_POS, "R1 wiper_pos", int'(wiper_pos), INIT_POS);
        rst_n = 1'b1;

        // R2 synchroniser latency on the external strobe
        set_sign(1'b1);
        adj_ext = 1'b1;
        @(negedge clk);
        check(adj_mode == 1'b0, "R2 after one edge", int'(adj_mode), 0);
        @(negedge clk);
        check(adj_mode == 1'b1, "R2 after two edges", int'(adj_mode), 1);
        repeat (6) @(negedge clk);
        adj_ext = 1'b0;
        repeat (8) @(negedge clk);

        // R3 R4 external cycles in both directions
        ext_cycle(1'b1);
        ext_cycle(1'b1);
        ext_cycle(1'b0);
        ext_cycle(1'b0);
        check(int'(wiper_pos) == 51, "R4 after ext cycles", int'(wiper_pos), 51);
        check(pulse_cnt == 5, "R3 one step per cycle", pulse_cnt, 5);

        // R8 hold between operations
        p0 = pulse_cnt;
        repeat (200) @(negedge clk);
        check(int'(wiper_pos) == 51, "R8 hold position", int'(wiper_pos), 51);
        check(pulse_cnt == p0, "R8 no steps", pulse_cnt, p0);

        // R7 power-up run with auto_en low
        set_sign(1'b1);
        f0 = fall_cnt;
        pwr_ok = 1'b1;
        repeat ((AUTO_CYCLES + 3) * 2 * DIV_HALF + 20) @(negedge clk);
        check(fall_cnt - f0 == AUTO_CYCLES, "R7 cycle count", fall_cnt - f0, AUTO_CYCLES);
        check(int'(wiper_pos) == 56, "R7 position", int'(wiper_pos), 56);
        repeat (100) @(negedge clk);
        check(fall_cnt - f0 == AUTO_CYCLES, "R7 stopped", fall_cnt - f0, AUTO_CYCLES);

        // R6 R5 free-running auto-null up to the top end
        f0 = fall_cnt;
        auto_en = 1'b1;
        repeat (10) @(negedge clk);
        width_chk = 1'b1;
        repeat (60 * 2 * DIV_HALF) @(negedge clk);
        width_chk = 1'b0;
        auto_en = 1'b0;
        repeat (40) @(negedge clk);
        check(fall_cnt - f0 >= 55, "R6 auto cycles", fall_cnt - f0, 55);
        check(int'(wiper_pos) == POS_MAX, "R5 top saturation", int'(wiper_pos), POS_MAX);
        f0 = fall_cnt;
        repeat (60) @(negedge clk);
        check(fall_cnt == f0 && !adj_mode, "R6 gated off", fall_cnt - f0, 0);

        // R5 run down to the bottom end
        set_sign(1'b0);
        auto_en = 1'b1;
        repeat (110 * 2 * DIV_HALF) @(negedge clk);
        auto_en = 1'b0;
        repeat (40) @(negedge clk);
        check(int'(wiper_pos) == 0, "R5 bottom saturation", int'(wiper_pos), 0);

        // R5 outward strobe at the bottom has no effect
        p0 = pulse_cnt;
        ext_cycle(1'b0);
        check(int'(wiper_pos) == 0, "R5 stays at 0", int'(wiper_pos), 0);
        check(pulse_cnt == p0, "R5 no step at 0", pulse_cnt, p0);
        ext_cycle(1'b1);
        check(int'(wiper_pos) == 1, "R5 leaves end", int'(wiper_pos), 1);

        check(exp_q.size() == 0, "R3 missing steps", exp_q.size(), 0);
        finish_run();
    end
endmodule